// File: doc/BRIEF.md
# One-wire bus master

This block is a byte-wide, register-mapped controller for a single-wire, open-drain serial bus. A host writes a command to start a bus reset. The block then checks whether any device answers with a presence pulse. Writing a byte to the data register starts a transfer of eight timed bit slots. In every slot the block drives the bit onto the line and samples the line, so each transfer sends one byte and receives one byte in the same pass. To read a byte from the bus, the host writes all ones and reads back what the devices pulled low.

All bus timing counts in bus microseconds. A programmable clock divisor produces one bus microsecond from the system clock. Completion events are kept in a status register: presence detect done, presence result, transmit buffer empty, transmit shift register empty, receive buffer full and receive shift register full. Each event except the presence result can raise a maskable interrupt, and the interrupt output polarity is programmable. The line itself is seen as a drive-low output plus a sensed input level.

Top module: `ow_master`

## Requirements
- R1: Registers are selected by index: 0 command, 1 data, 2 status, 3 interrupt enable, 4 divisor. All are 8 bits wide. Enable and divisor read back the last value written. The search-mode request (command bit 1) is stored, reads back in bit 1, and has no effect on bus activity.
- R2: One bus microsecond lasts (divisor + 1) clocks. The bus-low pulse of a slot carrying a 1 lasts 6 bus microseconds. The pulse of a slot carrying a 0 lasts 60 bus microseconds.
- R3: Writing 1 to command bit 0 while the bus is idle drives the line low for 480 bus microseconds, then releases it for 625. Command bit 0 reads 1 from the start of the reset until its end, and 0 afterwards.
- R4: Status bit 0 (presence done) is set 300 bus microseconds after the reset releases the line. Status bit 1 (presence result) then holds 0 if the line was sensed low between 60 and 300 bus microseconds after release, and 1 otherwise. It reads 1 after reset.
- R5: A byte transfer sends bits least significant first, in eight slots of 70 bus microseconds each. The line is sampled 15 bus microseconds into each slot. The received byte equals the transmitted byte ANDed with the bits the device pulls low.
- R6: Status bit 2 (transmit buffer empty) sets when a written byte moves into the shift register. Status bit 3 (transmit shift register empty) sets when the eighth slot ends.
- R7: At the end of a transfer, status bit 5 (receive shift register full) sets. The received byte then moves to the data register and status bit 4 (receive buffer full) sets. Reading the data register returns that byte and clears bit 4.
- R8: Reading the status register clears bits 0, 2, 3 and 5. Bits 1 and 4 are left unchanged.
- R9: The interrupt is active while any status bit is set whose enable bit (0, 2, 3, 4 or 5) is set. Enable bit 1 set makes the output high when active; clear makes it low when active. After reset the output is inactive, which means high.
- R10: Command bit 2 set drives the line low for as long as it stays set, and reads back as 0. Command bit 3 reads the sensed line level.
- R11: A byte written during a transfer waits in the buffer and starts when the current transfer ends. If the first received byte has not been read, the second one stays in the shift register until the data register is read, and then moves into it.
- R12: A reset command written while a byte transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register index |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; data valid the next cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt with programmable polarity |
| ow_drive_low | output | 1 | Pulls the open-drain line low when 1 |
| ow_sense | input | 1 | Sensed line level |

## Verification
The assertions check the rules that hold in every cycle: the force-low bit reaches the line in the next cycle, and the idle engine releases the line. They also check that the shift-register-empty flag follows each completed byte, that a status read leaves the presence result alone, that a data read clears the buffer-full flag, and that a masked interrupt stays at its inactive level. Only the bench scenarios can show the timing and data behaviour. That covers the measured pulse widths, the 300-microsecond presence point, the AND of sent and device bits, the buffered second byte, and the ignored reset request, all driven by a behavioural device on the line.

// File: rtl/ow_pkg.sv
`timescale 1ns/1ps
package ow_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] RI_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] RI_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] RI_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] RI_IEN  = 3'd3;
  localparam logic [ADDR_W-1:0] RI_DIV  = 3'd4;

  localparam int ST_W    = 6;
  localparam int ST_PD   = 0;
  localparam int ST_PDR  = 1;
  localparam int ST_TBE  = 2;
  localparam int ST_TSRE = 3;
  localparam int ST_RBF  = 4;
  localparam int ST_RSRF = 5;
  localparam int IEN_POL = 1;

  localparam logic [ST_W-1:0] IRQ_SRC_MASK = 6'b111101;
  localparam logic [ST_W-1:0] RD_CLR_MASK  = 6'b101101;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_RST_LOW,
    ENG_RST_HIGH,
    ENG_SLOT
  } eng_state_e;
endpackage

// File: rtl/ow_tick_gen.sv
`timescale 1ns/1ps
module ow_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;

  assign tick = (cnt_q >= div);

  always_comb begin
    if (restart || tick) cnt_n = '0;
    else                 cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/ow_bus_engine.sv
`timescale 1ns/1ps
module ow_bus_engine
  import ow_pkg::*;
#(
  parameter int RST_LOW_US  = 480,
  parameter int RST_HIGH_US = 625,
  parameter int PDH_US      = 60,
  parameter int PDL_US      = 240,
  parameter int SLOT_US     = 70,
  parameter int W1_LOW_US   = 6,
  parameter int W0_LOW_US   = 60,
  parameter int SAMPLE_US   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_lvl,
  input  logic              start_rst,
  input  logic              start_byte,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              drive_low,
  output logic              idle,
  output logic              rst_busy,
  output logic              pres_done,
  output logic              pres_absent,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int T_MAX = (RST_HIGH_US > RST_LOW_US) ? RST_HIGH_US : RST_LOW_US;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] T_RSTL_END = CNT_W'(RST_LOW_US - 1);
  localparam logic [CNT_W-1:0] T_RSTH_END = CNT_W'(RST_HIGH_US - 1);
  localparam logic [CNT_W-1:0] T_WIN_LO   = CNT_W'(PDH_US);
  localparam logic [CNT_W-1:0] T_WIN_END  = CNT_W'(PDH_US + PDL_US - 1);
  localparam logic [CNT_W-1:0] T_SLOT_END = CNT_W'(SLOT_US - 1);
  localparam logic [CNT_W-1:0] T_SAMPLE   = CNT_W'(SAMPLE_US);
  localparam logic [CNT_W-1:0] T_W1       = CNT_W'(W1_LOW_US);
  localparam logic [CNT_W-1:0] T_W0       = CNT_W'(W0_LOW_US);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(BYTE_W - 1);

  eng_state_e        state_q, state_n;
  logic [CNT_W-1:0]  t_q, t_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] rx_q, rx_n;
  logic              seen_q, seen_n;
  logic              low_now;

  assign idle     = (state_q == ENG_IDLE);
  assign rst_busy = (state_q == ENG_RST_LOW) || (state_q == ENG_RST_HIGH);
  assign rx_byte  = rx_q;
  assign low_now  = (t_q >= T_WIN_LO) && (t_q <= T_WIN_END) && !bus_lvl;

  always_comb begin
    case (state_q)
      ENG_RST_LOW: drive_low = 1'b1;
      ENG_SLOT:    drive_low = (t_q < (sh_q[0] ? T_W1 : T_W0));
      default:     drive_low = 1'b0;
    endcase
  end

  always_comb begin
    state_n     = state_q;
    t_n         = t_q;
    bit_n       = bit_q;
    sh_n        = sh_q;
    rx_n        = rx_q;
    seen_n      = seen_q;
    pres_done   = 1'b0;
    pres_absent = 1'b0;
    byte_done   = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (start_rst) begin
          state_n = ENG_RST_LOW;
          t_n     = '0;
          seen_n  = 1'b0;
        end else if (start_byte) begin
          state_n = ENG_SLOT;
          t_n     = '0;
          bit_n   = '0;
          sh_n    = tx_byte;
        end
      end
      ENG_RST_LOW: begin
        if (tick) begin
          if (t_q == T_RSTL_END) begin
            state_n = ENG_RST_HIGH;
            t_n     = '0;
          end else begin
            t_n = t_q + 1'b1;
          end
        end
      end
      ENG_RST_HIGH: begin
        if (tick) begin
          if (low_now) seen_n = 1'b1;
          if (t_q == T_WIN_END) begin
            pres_done   = 1'b1;
            pres_absent = !(seen_q || low_now);
          end
          if (t_q == T_RSTH_END) begin
            state_n = ENG_IDLE;
            t_n     = '0;
          end else begin
            t_n = t_q + 1'b1;
          end
        end
      end
      ENG_SLOT: begin
        if (tick) begin
          if (t_q == T_SAMPLE) rx_n = {bus_lvl, rx_q[BYTE_W-1:1]};
          if (t_q == T_SLOT_END) begin
            t_n = '0;
            if (bit_q == LAST_BIT) begin
              state_n   = ENG_IDLE;
              byte_done = 1'b1;
            end else begin
              bit_n = bit_q + 1'b1;
              sh_n  = {1'b0, sh_q[BYTE_W-1:1]};
            end
          end else begin
            t_n = t_q + 1'b1;
          end
        end
      end
      default: state_n = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      t_q     <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      t_q     <= t_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      rx_q    <= rx_n;
      seen_q  <= seen_n;
    end
  end
endmodule

// File: rtl/ow_master.sv
`timescale 1ns/1ps
module ow_master
  import ow_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int RST_LOW_US  = 480,
  parameter int RST_HIGH_US = 625,
  parameter int PDH_US      = 60,
  parameter int PDL_US      = 240,
  parameter int SLOT_US     = 70,
  parameter int W1_LOW_US   = 6,
  parameter int W0_LOW_US   = 60,
  parameter int SAMPLE_US   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  output logic              ow_drive_low,
  input  logic              ow_sense
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // line level synchroniser
  logic sense_meta_q, sense_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sense_meta_q <= 1'b1;
      sense_q      <= 1'b1;
    end else begin
      sense_meta_q <= ow_sense;
      sense_q      <= sense_meta_q;
    end
  end

  logic              sra_q, force_q;
  logic [BYTE_W-1:0] tx_buf_q, rx_buf_q, rx_sh_q, ien_q, rdata_q;
  logic [DIV_W-1:0]  div_q;
  logic              tx_full_q, rx_pend_q, drive_q;
  logic [ST_W-1:0]   st_q, st_n;

  logic              wr_cmd, wr_data, wr_ien, wr_div, rd_data, rd_stat;
  logic              start_rst, start_byte, move_rx;
  logic              tick, eng_drive, eng_idle, rst_busy;
  logic              pres_done, pres_absent, byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              irq_act;

  assign wr_cmd  = reg_wr && (reg_addr == RI_CMD);
  assign wr_data = reg_wr && (reg_addr == RI_DATA);
  assign wr_ien  = reg_wr && (reg_addr == RI_IEN);
  assign wr_div  = reg_wr && (reg_addr == RI_DIV);
  assign rd_data = reg_rd && (reg_addr == RI_DATA);
  assign rd_stat = reg_rd && (reg_addr == RI_STAT);

  assign start_rst  = wr_cmd && reg_wdata[0] && eng_idle;
  assign start_byte = eng_idle && tx_full_q && !start_rst;
  assign move_rx    = rx_pend_q && !st_q[ST_RBF];

  ow_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (start_rst || start_byte),
    .div     (div_q),
    .tick    (tick)
  );

  ow_bus_engine #(
    .RST_LOW_US (RST_LOW_US),
    .RST_HIGH_US(RST_HIGH_US),
    .PDH_US     (PDH_US),
    .PDL_US     (PDL_US),
    .SLOT_US    (SLOT_US),
    .W1_LOW_US  (W1_LOW_US),
    .W0_LOW_US  (W0_LOW_US),
    .SAMPLE_US  (SAMPLE_US)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (tick),
    .bus_lvl    (sense_q),
    .start_rst  (start_rst),
    .start_byte (start_byte),
    .tx_byte    (tx_buf_q),
    .drive_low  (eng_drive),
    .idle       (eng_idle),
    .rst_busy   (rst_busy),
    .pres_done  (pres_done),
    .pres_absent(pres_absent),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte)
  );

  // status next state: set events win over read clears
  always_comb begin
    st_n = st_q;
    if (rd_stat) st_n = st_q & ~RD_CLR_MASK;
    if (rd_data) st_n[ST_RBF] = 1'b0;
    if (pres_done) begin
      st_n[ST_PD]  = 1'b1;
      st_n[ST_PDR] = pres_absent;
    end
    if (start_byte) st_n[ST_TBE] = 1'b1;
    if (byte_done) begin
      st_n[ST_TSRE] = 1'b1;
      st_n[ST_RSRF] = 1'b1;
    end
    if (move_rx) st_n[ST_RBF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= 6'b000010;
    else             st_q <= st_n;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sra_q   <= 1'b0;
      force_q <= 1'b0;
    end else if (wr_cmd) begin
      sra_q   <= reg_wdata[1];
      force_q <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ien_q <= '0;
    else if (wr_ien) ien_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) div_q <= '0;
    else if (wr_div) div_q <= DIV_W'(reg_wdata);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
    end else if (wr_data) begin
      tx_buf_q  <= reg_wdata;
      tx_full_q <= 1'b1;
    end else if (start_byte) begin
      tx_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_sh_q   <= '0;
      rx_pend_q <= 1'b0;
    end else if (byte_done) begin
      rx_sh_q   <= rx_byte;
      rx_pend_q <= 1'b1;
    end else if (move_rx) begin
      rx_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rx_buf_q <= '0;
    else if (move_rx) rx_buf_q <= rx_sh_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RI_CMD:  rdata_q <= {4'b0000, sense_q, 1'b0, sra_q, rst_busy};
        RI_DATA: rdata_q <= rx_buf_q;
        RI_STAT: rdata_q <= {2'b00, st_q};
        RI_IEN:  rdata_q <= ien_q;
        RI_DIV:  rdata_q <= BYTE_W'(div_q);
        default: rdata_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) drive_q <= 1'b0;
    else             drive_q <= eng_drive || force_q;
  end

  assign irq_act      = |(st_q & ien_q[ST_W-1:0] & IRQ_SRC_MASK);
  assign irq          = ien_q[IEN_POL] ? irq_act : !irq_act;
  assign reg_rdata    = rdata_q;
  assign ow_drive_low = drive_q;
endmodule

// File: rtl/ow_master_chk.sv
`timescale 1ns/1ps
module ow_master_chk
  import ow_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              irq,
  input logic              ow_drive_low,
  input logic              force_q,
  input logic              eng_idle,
  input logic              byte_done,
  input logic              pres_done,
  input logic              rx_pend_q,
  input logic [ST_W-1:0]   st_q,
  input logic [BYTE_W-1:0] ien_q
);
  a_r10_force_reaches_line: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |=> ow_drive_low);

  a_r3_idle_releases_line: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && !force_q) |=> !ow_drive_low);

  a_r6_tsre_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> st_q[ST_TSRE]);

  a_r8_pdr_kept_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == RI_STAT && !pres_done) |=> $stable(st_q[ST_PDR]));

  a_r7_rbf_cleared_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == RI_DATA && !rx_pend_q) |=> !st_q[ST_RBF]);

  a_r9_masked_is_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ien_q[ST_W-1:0] & IRQ_SRC_MASK) == '0) |-> (irq == !ien_q[IEN_POL]));
endmodule

bind ow_master ow_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .reg_addr    (reg_addr),
  .reg_rd      (reg_rd),
  .irq         (irq),
  .ow_drive_low(ow_drive_low),
  .force_q     (force_q),
  .eng_idle    (eng_idle),
  .byte_done   (byte_done),
  .pres_done   (pres_done),
  .rx_pend_q   (rx_pend_q),
  .st_q        (st_q),
  .ien_q       (ien_q)
);

// File: tb/ow_master_bench.sv
`timescale 1ns/1ps
module ow_master_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  DIVV       = 3;
  localparam real TCK        = (DIVV + 1) * CLK_PERIOD;
  localparam int  WD_CYCLES  = 150000;
  localparam int  NVEC       = 4;
  localparam logic [15:0] VEC [NVEC] = '{16'hA5FF, 16'h3CF0, 16'hFF5A, 16'h81FF};

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, drv, sense;
  logic       dev_low = 1'b0;
  logic       pres_en;
  logic [7:0] dev_byte;
  logic [2:0] dev_bit = 3'd0;
  realtime    t_fall = 0;
  int         n_checks = 0, n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sense = !(drv || dev_low);

  ow_master u_ow_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .ow_drive_low(drv), .ow_sense(sense)
  );

  // behavioural device on the line
  always @(posedge drv) t_fall = $realtime;
  always @(negedge drv) begin
    realtime dur;
    dur = $realtime - t_fall;
    if (dur > 300 * TCK) begin
      dev_bit = 3'd0;
      if (pres_en) begin
        #(80 * TCK) dev_low = 1'b1;
        #(120 * TCK) dev_low = 1'b0;
      end
    end else begin
      if (dur < 15 * TCK && !dev_byte[dev_bit]) begin
        dev_low = 1'b1;
        #(25 * TCK) dev_low = 1'b0;
      end
      dev_bit = dev_bit + 1'b1;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_irq(input logic lvl, input int max, output logic ok);
    ok = 1'b0;
    for (int n = 0; n < max; n++) begin
      @(negedge clk);
      if (irq === lvl) begin ok = 1'b1; break; end
    end
  endtask

  task automatic width_chk(input string req, input real exp);
    realtime t0, t1;
    @(posedge drv); t0 = $realtime;
    @(negedge drv); t1 = $realtime;
    n_checks++;
    if ((t1 - t0) < exp - 1.0 || (t1 - t0) > exp + 1.0) begin
      n_errors++;
      $display("FAIL %s: actual width=%0.1f expected=%0.1f", req, t1 - t0, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(WD_CYCLES * CLK_PERIOD);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic       ok;
    realtime    tr, ti;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    pres_en = 1'b0; dev_byte = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    rd(3'd2, d); chk("R4 reset status", d, 8'h02);
    chk("R9 reset irq inactive high", {7'd0, irq}, 8'h01);
    rd(3'd4, d); chk("R1 reset divisor", d, 8'h00);

    // R1 register readback
    wr(3'd4, 8'(DIVV)); rd(3'd4, d); chk("R1 divisor readback", d, 8'(DIVV));
    wr(3'd3, 8'h03); rd(3'd3, d); chk("R1 enable readback", d, 8'h03);
    chk("R9 active-high idle", {7'd0, irq}, 8'h00);
    wr(3'd0, 8'h02); rd(3'd0, d); chk("R1 search bit readback", d & 8'h07, 8'h02);
    wr(3'd0, 8'h00);

    // R3 / R4 reset without a device
    wr(3'd0, 8'h01);
    width_chk("R3 reset low width", 480.0 * TCK);
    tr = $realtime;
    rd(3'd0, d); chk("R3 busy during reset", d & 8'h01, 8'h01);
    wait_irq(1'b1, 400 * (DIVV + 1), ok); ti = $realtime;
    chk("R4 presence irq seen", {7'd0, ok}, 8'h01);
    n_checks++;
    if ((ti - tr) < 300.0 * TCK - 3 * CLK_PERIOD || (ti - tr) > 300.0 * TCK + 3 * CLK_PERIOD) begin
      n_errors++;
      $display("FAIL R4 presence timing: actual=%0.1f expected=%0.1f", ti - tr, 300.0 * TCK);
    end
    rd(3'd2, d); chk("R4 no device result", d & 8'h03, 8'h03);
    @(negedge clk); chk("R8 pd cleared irq low", {7'd0, irq}, 8'h00);
    repeat (340 * (DIVV + 1)) @(negedge clk);
    rd(3'd0, d); chk("R3 reset finished", d & 8'h01, 8'h00);

    // R4 reset with a device
    pres_en = 1'b1;
    wr(3'd0, 8'h01);
    wait_irq(1'b1, 1200 * (DIVV + 1), ok);
    chk("R4 presence irq with device", {7'd0, ok}, 8'h01);
    rd(3'd2, d); chk("R4 device present result", d & 8'h03, 8'h01);
    repeat (340 * (DIVV + 1)) @(negedge clk);

    // R2 R5 R6 R7 R8 vector table
    wr(3'd3, 8'h0A);
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] tx, dv;
      tx = VEC[i][15:8]; dv = VEC[i][7:0];
      dev_byte = dv;
      wr(3'd1, tx);
      width_chk("R2 first slot width", (tx[0] ? 6.0 : 60.0) * TCK);
      wait_irq(1'b1, 700 * (DIVV + 1), ok);
      chk("R6 transfer done irq", {7'd0, ok}, 8'h01);
      repeat (4) @(negedge clk);
      rd(3'd2, d); chk("R6 R7 flags after byte", d & 8'h3C, 8'h3C);
      rd(3'd1, d); chk("R5 received byte", d, tx & dv);
      rd(3'd2, d); chk("R8 R7 flags cleared", d & 8'h3D, 8'h00);
    end

    // R9 active-low polarity
    dev_byte = 8'hFF;
    wr(3'd3, 8'h08);
    chk("R9 active-low idle", {7'd0, irq}, 8'h01);
    wr(3'd1, 8'h66);
    wait_irq(1'b0, 700 * (DIVV + 1), ok);
    chk("R9 active-low asserted", {7'd0, ok}, 8'h01);
    repeat (4) @(negedge clk);
    rd(3'd2, d);
    rd(3'd1, d); chk("R5 read all-ones device", d, 8'h66);
    chk("R9 active-low released", {7'd0, irq}, 8'h01);

    // R12 reset request during a transfer is ignored
    wr(3'd3, 8'h0A);
    wr(3'd1, 8'h99);
    repeat (8) @(negedge clk);
    wr(3'd0, 8'h01);
    rd(3'd0, d); chk("R12 no reset started", d & 8'h01, 8'h00);
    wait_irq(1'b1, 700 * (DIVV + 1), ok);
    repeat (4) @(negedge clk);
    rd(3'd2, d); chk("R12 no presence event", d & 8'h01, 8'h00);
    rd(3'd1, d); chk("R12 byte intact", d, 8'h99);

    // R11 back-to-back bytes
    wr(3'd1, 8'h12);
    repeat (4) @(negedge clk);
    wr(3'd1, 8'h34);
    repeat (1180 * (DIVV + 1)) @(negedge clk);
    rd(3'd2, d); chk("R11 both buffers full", d & 8'h30, 8'h30);
    rd(3'd1, d); chk("R11 first byte", d, 8'h12);
    repeat (3) @(negedge clk);
    rd(3'd1, d); chk("R11 second byte", d, 8'h34);

    // R10 force low and live level
    wr(3'd0, 8'h04);
    repeat (4) @(negedge clk);
    chk("R10 line forced low", {7'd0, drv}, 8'h01);
    rd(3'd0, d); chk("R10 level low, bit2 reads 0", d & 8'h0C, 8'h00);
    wr(3'd0, 8'h00);
    repeat (4) @(negedge clk);
    rd(3'd0, d); chk("R10 level high", d & 8'h08, 8'h08);

    summary();
  end
endmodule